// File: doc/BRIEF.md
# Error Count Snapshot Controller

This block sits beside a line framer. It keeps one running accumulator for each error event line. On each update it copies every accumulator into a holding register that the host can read, and it clears the accumulator in the same clock edge. No event is lost or counted twice across an update. Accumulators stop at all ones and do not wrap.

Two sources can start an update, and `manual_mode` selects between them. With `manual_mode` low, a divider of the system clock produces an update tick every `TICK_DIV` cycles. This gives the host one full period to read the held values before they are overwritten. With `manual_mode` high, the divider is held and the block waits for a manual trigger. That trigger is a 0-to-1 change of the OR of two signals: `upd_pin`, which passes through a two-flop synchronizer, and `upd_bit`, a synchronous control bit. Each update raises `snap_done` for one cycle. `busy` is high from the cycle the trigger is accepted until the done cycle.

The controller is a three-state machine:
- S_IDLE: no update is in progress.
- S_CAPTURE: the trigger has been accepted. The copy and clear happen at the edge that leaves this state.
- S_REPORT: `snap_done` is high.

Transitions:
- IDLE→CAPTURE: on a trigger, or on a trigger held pending.
- CAPTURE→REPORT: always.
- REPORT→IDLE: always.

A trigger that arrives in CAPTURE or REPORT is held as pending and is served from IDLE.

Top module: `err_snap_ctrl`

## Requirements
- R1: After reset, every field of `snap_flat` is 0, and `snap_done` and `busy` are low.
- R2: With `manual_mode` low, an update occurs every `TICK_DIV` clock cycles. Each update gives one `snap_done` pulse, one cycle long.
- R3: Between updates, `snap_flat` holds its value. It changes only in a cycle where `snap_done` is high.
- R4: With `manual_mode` high, no update occurs without a manual trigger, however long the wait.
- R5: With `manual_mode` high, a 0-to-1 change of (`upd_bit` OR synchronized `upd_pin`) starts exactly one update. `snap_done` is seen 2 cycles after `upd_bit` rises and 4 cycles after `upd_pin` rises. The new values are visible in that same cycle, well inside 100 ns at a 50 MHz clock.
- R6: With `manual_mode` low, changes on `upd_bit` and `upd_pin` cause no update.
- R7: Holding the trigger high gives no further update. Another update needs the trigger to go low and then high again.
- R8: On update, each accumulator is copied and cleared in one edge. An event present in the copy cycle is counted in the new window. The sum of consecutive snapshots equals the number of events.
- R9: An accumulator at all ones stays at all ones when more events arrive.
- R10: `busy` is high from the cycle after a trigger is accepted through the cycle `snap_done` is high.
- R11: Field i of `snap_flat` occupies bits [i*CNT_W +: CNT_W] and counts events on `err_evt[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | NUM_CNT | One strobe per error type, counted once per cycle while high |
| manual_mode | input | 1 | 0 selects timed updates, 1 selects manual updates |
| upd_bit | input | 1 | Synchronous manual update control bit |
| upd_pin | input | 1 | Asynchronous manual update pin |
| snap_flat | output | NUM_CNT*CNT_W | Held counts, one field per error type |
| snap_done | output | 1 | One-cycle pulse when fresh counts are held |
| busy | output | 1 | An update is in progress |

## Verification
Each result has a fixed latency:
- A control-bit trigger reaches S_CAPTURE at the first edge after it is driven, and gives `snap_done` with new values at the second edge.
- A pin trigger first spends two edges in the synchronizer, so `snap_done` comes at the fourth edge.
- A timed update recurs exactly `TICK_DIV` edges after the previous one.
- An event is counted at the edge that follows the one where it is driven.

The bench drives on falling edges and counts falling edges from the stimulus to the `snap_done` it observes. It compares that count to the latencies above and reads the held fields in the done cycle. Windows in which nothing should happen are scanned cycle by cycle for a stray pulse.

// File: rtl/err_snap_pkg.sv
package err_snap_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_CAPTURE = 2'd1,
        S_REPORT  = 2'd2
    } snap_state_t;
endpackage

// File: rtl/err_snap_tick.sv
module err_snap_tick #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/err_snap_trig.sv
module err_snap_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic ctl_bit,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   combined;
    logic                   combined_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
        end
    end

    assign combined = sync_q[SYNC_STAGES-1] | ctl_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            combined_q <= 1'b0;
        end else begin
            combined_q <= combined;
        end
    end

    assign rise = combined & ~combined_q;
endmodule

// File: rtl/err_snap_accum.sv
module err_snap_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             load,
    output logic [CNT_W-1:0] acc,
    output logic [CNT_W-1:0] held
);
    localparam logic [CNT_W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            held <= '0;
        end else if (load) begin
            held <= acc;
            acc  <= evt ? CNT_W'(1) : '0;
        end else if (evt && acc != FULL) begin
            acc <= acc + 1'b1;
        end
    end
endmodule

// File: rtl/err_snap_ctrl.sv
module err_snap_ctrl
    import err_snap_pkg::*;
#(
    parameter int NUM_CNT     = 4,
    parameter int CNT_W       = 16,
    parameter int TICK_DIV    = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT-1:0]       err_evt,
    input  logic                     manual_mode,
    input  logic                     upd_bit,
    input  logic                     upd_pin,
    output logic [NUM_CNT*CNT_W-1:0] snap_flat,
    output logic                     snap_done,
    output logic                     busy
);
    localparam int FLAT_W = NUM_CNT * CNT_W;

    snap_state_t          state, state_nx;
    logic                 tick;
    logic                 man_rise;
    logic                 trig;
    logic                 pending;
    logic                 capture;
    logic [FLAT_W-1:0]    acc_flat;

    err_snap_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!manual_mode),
        .tick (tick)
    );

    err_snap_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(upd_pin),
        .ctl_bit  (upd_bit),
        .rise     (man_rise)
    );

    assign trig = tick | (manual_mode & man_rise);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (trig || pending) state_nx = S_CAPTURE;
            S_CAPTURE: state_nx = S_REPORT;
            S_REPORT:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // trigger arriving mid-update is served afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (state == S_IDLE) begin
            pending <= 1'b0;
        end else if (trig) begin
            pending <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        capture   = 1'b0;
        snap_done = 1'b0;
        busy      = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_CAPTURE: begin capture = 1'b1; busy = 1'b1; end
            S_REPORT:  begin snap_done = 1'b1; busy = 1'b1; end
            default:   ;
        endcase
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_acc
        err_snap_accum #(.CNT_W(CNT_W)) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (err_evt[i]),
            .load (capture),
            .acc  (acc_flat[i*CNT_W +: CNT_W]),
            .held (snap_flat[i*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/err_snap_chk.sv
module err_snap_chk #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CNT-1:0]       err_evt,
    input logic                     capture,
    input logic                     snap_done,
    input logic                     busy,
    input logic [NUM_CNT*CNT_W-1:0] acc_flat,
    input logic [NUM_CNT*CNT_W-1:0] snap_flat
);
    localparam logic [CNT_W-1:0] FULL = '1;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_done |=> !snap_done);

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_done |-> busy);

    assert_capture_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> snap_done);

    assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_flat) |-> snap_done);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_flat[i*CNT_W +: CNT_W] == FULL && err_evt[i] && !capture)
            |=> acc_flat[i*CNT_W +: CNT_W] == FULL);

        assert_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> snap_flat[i*CNT_W +: CNT_W] == $past(acc_flat[i*CNT_W +: CNT_W]));
    end
endmodule

bind err_snap_ctrl err_snap_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .capture  (capture),
    .snap_done(snap_done),
    .busy     (busy),
    .acc_flat (acc_flat),
    .snap_flat(snap_flat)
);

// File: tb/err_snap_ctrl_test.sv
module err_snap_ctrl_test;
    localparam int NC  = 2;
    localparam int W   = 4;
    localparam int DIV = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     err_evt = '0;
    logic              manual_mode = 1'b1;
    logic              upd_bit = 1'b0;
    logic              upd_pin = 1'b0;
    logic [NC*W-1:0]   snap_flat;
    logic              snap_done;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    err_snap_ctrl #(.NUM_CNT(NC), .CNT_W(W), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .manual_mode(manual_mode),
        .upd_bit(upd_bit), .upd_pin(upd_pin), .snap_flat(snap_flat),
        .snap_done(snap_done), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic int fld(int i);
        return int'(snap_flat[i*W +: W]);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_done(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!snap_done && n < limit);
    endtask

    task automatic pulse_evt(int ch, int count);
        for (int k = 0; k < count; k++) begin
            err_evt[ch] = 1'b1;
            @(negedge clk);
            err_evt[ch] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic count_done(int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (snap_done) hits++;
        end
    endtask

    task automatic t_reset;
        check(snap_flat == '0, "R1 snap", int'(snap_flat), 0);
        check(!snap_done && !busy, "R1 done/busy", int'({snap_done, busy}), 0);
    endtask

    task automatic t_manual_bit;
        int n, hits, first;
        pulse_evt(0, 3);
        pulse_evt(1, 5);
        upd_bit = 1'b1;
        @(negedge clk);
        check(busy && !snap_done, "R10 busy before done", int'({busy, snap_done}), 2);
        @(negedge clk);
        check(snap_done, "R5 done after 2 cycles", int'(snap_done), 1);
        check(fld(0) == 3, "R11 field0", fld(0), 3);
        check(fld(1) == 5, "R11 field1", fld(1), 5);
        @(negedge clk);
        check(!snap_done, "R5 one-cycle pulse", int'(snap_done), 0);
        first = int'(snap_flat);
        count_done(10, hits);
        check(hits == 0, "R7 held level no retrigger", hits, 0);
        check(int'(snap_flat) == first, "R3 snap held", int'(snap_flat), first);
        upd_bit = 1'b0;
        cycles(2);
        upd_bit = 1'b1;
        wait_done(n, 10);
        check(n == 2, "R7 rearm latency", n, 2);
        check(snap_flat == '0, "R7 rearm fresh window", int'(snap_flat), 0);
        upd_bit = 1'b0;
        cycles(3);
    endtask

    task automatic t_manual_pin;
        int n;
        pulse_evt(1, 2);
        upd_pin = 1'b1;
        wait_done(n, 10);
        check(n == 4, "R5 pin latency", n, 4);
        check(fld(1) == 2, "R5 pin snapshot", fld(1), 2);
        upd_pin = 1'b0;
        cycles(4);
    endtask

    task automatic t_no_loss;
        int n, a, b;
        err_evt[0] = 1'b1;
        cycles(5);
        upd_bit = 1'b1;
        wait_done(n, 10);
        a = fld(0);
        cycles(10 - 5 - n);
        err_evt[0] = 1'b0;
        upd_bit = 1'b0;
        cycles(2);
        upd_bit = 1'b1;
        wait_done(n, 10);
        b = fld(0);
        upd_bit = 1'b0;
        check(a + b == 10, "R8 no loss across update", a + b, 10);
        check(a == 6, "R8 copy-cycle event to new window", a, 6);
        cycles(2);
    endtask

    task automatic t_saturate;
        int n;
        pulse_evt(1, 20);
        upd_bit = 1'b1;
        wait_done(n, 10);
        check(fld(1) == 15, "R9 saturation", fld(1), 15);
        upd_bit = 1'b0;
        cycles(2);
    endtask

    task automatic t_no_tick;
        int hits;
        count_done(3 * DIV, hits);
        check(hits == 0, "R4 no timed update in manual mode", hits, 0);
    endtask

    task automatic t_auto;
        int n, hits, held;
        manual_mode = 1'b0;
        wait_done(n, 2 * DIV);
        check(n <= DIV + 1, "R2 first tick", n, DIV + 1);
        pulse_evt(0, 2);
        held = int'(snap_flat);
        upd_bit = 1'b1;
        upd_pin = 1'b1;
        count_done(8, hits);
        upd_bit = 1'b0;
        upd_pin = 1'b0;
        count_done(8, hits);
        check(hits == 0, "R6 manual inputs ignored", hits, 0);
        check(int'(snap_flat) == held, "R6 snap untouched", int'(snap_flat), held);
        wait_done(n, 2 * DIV);
        check(n == DIV - 20, "R2 period", n + 20, DIV);
        check(fld(0) == 2, "R2 timed snapshot", fld(0), 2);
        wait_done(n, 2 * DIV);
        check(n == DIV, "R2 steady period", n, DIV);
        check(fld(0) == 0, "R2 empty window", fld(0), 0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_manual_bit();
        t_manual_pin();
        t_no_loss();
        t_saturate();
        t_no_tick();
        t_auto();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule